// File: doc/BRIEF.md
# Low-Power GPIO Controller with Interrupts

This block controls a bank of 22 general-purpose pins in an always-on power domain. Software reaches it over a simple 32-bit word-addressed register bus with a combinational read path. Each pin has an output data bit, an output-enable bit and an interrupt status bit. All three registers have a direct address and two atomic aliases: one sets bits and one clears bits. Per-pin data always sits in bits [31:10] of a word, so pin n is bit n+10.

Pad inputs pass through a two-flop synchroniser before they reach the readable input register and the event detectors. Each pin has its own configuration word, which selects:
- open-drain or push-pull drive,
- one of six trigger choices: off, rising, falling, any edge, low level or high level,
- whether the pin may raise a wake-up request.

Detected events set the status bits. The OR of all status bits drives the interrupt line. Events on pins with wake-up enabled raise the registered wake request.

The design has no sequencing state machine. Its state is the three pin registers, the configuration array, the synchroniser and the previous-level register.

Top module: `lpg_ctrl`

Word addresses:
| Address | Register |
|---|---|
| 0 | output data |
| 1 | output set alias |
| 2 | output clear alias |
| 3 | output enable |
| 4 | output enable set alias |
| 5 | output enable clear alias |
| 6 | interrupt status |
| 7 | interrupt status set alias |
| 8 | interrupt status clear alias |
| 9 | input level, read-only |
| 16+n | configuration word of pin n |

Aliases and unmapped addresses read as zero.

## Requirements
- R1: After reset, every readable register is zero, all pad enables and outputs are 0, and the interrupt and wake outputs are 0.
- R2: Pin n is bit n+10 of the output, enable, status and input words. Bits [9:0] of these words always read zero. A write to a direct address loads bits [31:10].
- R3: Writing 1 to a bit at a set alias sets that bit, and writing 1 at a clear alias clears it. Bits written 0 at either alias keep their value.
- R4: The input word shows each pad level exactly two clock edges after the pad changes. Writes to the input address have no effect.
- R5: The trigger field selects edge detection between the current and previous synchronised level. Code 1 sets status on a rising edge, code 2 on a falling edge and code 3 on either.
- R6: Code 4 sets status on every cycle the synchronised level is low, and code 5 on every cycle it is high. Codes 0, 6 and 7 never set status.
- R7: When a detected event and a clear-alias or direct write hit the same status bit in one cycle, the bit ends up set.
- R8: The interrupt output is high exactly when some status bit is set.
- R9: With the drive bit 0, a pad is driven from the data bit and the enable bit. With the drive bit 1, the pad output is 0 and the pad is enabled only when the enable bit is 1 and the data bit is 0.
- R10: The wake output is high in the cycle after an event on a pin whose wake bit is set, and low otherwise.
- R11: In a configuration word, bit 2 is the drive bit, bits [9:7] are the trigger code and bit 10 is the wake bit. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_sel | input | 1 | bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from the address |
| pad_in | input | 22 | raw pad levels |
| pad_out | output | 22 | pad output levels |
| pad_oe | output | 22 | pad output enables |
| irq_o | output | 1 | combined interrupt |
| wake_o | output | 1 | wake-up request |

## Verification
A corrupted data, enable or drive bit shows on pad_out or pad_oe at the next falling edge after the faulty clock edge. It also shows on the next read of that register. A wrong synchroniser stage or previous-level value shifts the input word by a cycle. It also produces a missing or spurious status bit, which reaches irq_o one edge later. The bench compares a cycle-accurate model against every output on every cycle. A fault therefore surfaces within one clock of reaching a port.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    localparam int WORD_W  = 32;
    localparam int PIN_LSB = 10;

    // word addresses
    localparam int REG_OUT     = 0;
    localparam int REG_OUT_SET = 1;
    localparam int REG_OUT_CLR = 2;
    localparam int REG_OE      = 3;
    localparam int REG_OE_SET  = 4;
    localparam int REG_OE_CLR  = 5;
    localparam int REG_IRQ     = 6;
    localparam int REG_IRQ_SET = 7;
    localparam int REG_IRQ_CLR = 8;
    localparam int REG_IN      = 9;
    localparam int REG_CFG0    = 16;

    // configuration word layout
    localparam int CFG_OD_BIT   = 2;
    localparam int CFG_TRIG_LSB = 7;
    localparam int CFG_WAKE_BIT = 10;

    typedef enum logic [2:0] {
        TRG_NONE = 3'd0,
        TRG_RISE = 3'd1,
        TRG_FALL = 3'd2,
        TRG_BOTH = 3'd3,
        TRG_LOW  = 3'd4,
        TRG_HIGH = 3'd5
    } trig_e;

    typedef struct packed {
        logic       wake;
        logic [2:0] trig;
        logic       od;
    } pin_cfg_t;
endpackage

// File: rtl/lpg_sync.sv
module lpg_sync #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lpg_detect.sv
module lpg_detect
    import lpg_pkg::*;
#(
    parameter int N = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     lvl,
    input  logic [N-1:0][2:0] trig,
    output logic [N-1:0]     hit
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            case (trig_e'(trig[i]))
                TRG_RISE: hit[i] =  lvl[i] & ~prev[i];
                TRG_FALL: hit[i] = ~lvl[i] &  prev[i];
                TRG_BOTH: hit[i] =  lvl[i] ^  prev[i];
                TRG_LOW:  hit[i] = ~lvl[i];
                TRG_HIGH: hit[i] =  lvl[i];
                default:  hit[i] = 1'b0;
            endcase
        end

        // R5: a rising-edge event cannot repeat on the following cycle
        a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && trig[i] == TRG_RISE) |=> !(hit[i] && trig[i] == TRG_RISE));
    end
endmodule

// File: rtl/lpg_drive.sv
module lpg_drive #(
    parameter int N = 22
) (
    input  logic [N-1:0] od,
    input  logic [N-1:0] dat,
    input  logic [N-1:0] en,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pad
        always_comb begin
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = en[i] & ~dat[i];
            end else begin
                pad_out[i] = dat[i];
                pad_oe[i]  = en[i];
            end
        end
    end
endmodule

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
    import lpg_pkg::*;
#(
    parameter int NPIN = 22,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic            irq_o,
    output logic            wake_o
);
    localparam int PIN_MSB = PIN_LSB + NPIN - 1;

    logic                  wr;
    logic [NPIN-1:0]       wbits;
    logic [NPIN-1:0]       out_q, oe_q, st_q, st_d, st_base;
    logic [NPIN-1:0]       lvl, hit;
    logic [NPIN-1:0]       od_v, wake_v;
    logic [NPIN-1:0][2:0]  trig_v;
    pin_cfg_t              cfg_q [NPIN];
    logic                  wake_q;
    logic                  unused_wbits;

    assign wr           = bus_sel & bus_wr;
    assign wbits        = bus_wdata[PIN_MSB:PIN_LSB];
    assign unused_wbits = ^{bus_wdata[1:0], bus_wdata[6:3]};

    // data and enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
        end else if (wr) begin
            case (bus_addr)
                AW'(REG_OUT):     out_q <= wbits;
                AW'(REG_OUT_SET): out_q <= out_q | wbits;
                AW'(REG_OUT_CLR): out_q <= out_q & ~wbits;
                AW'(REG_OE):      oe_q  <= wbits;
                AW'(REG_OE_SET):  oe_q  <= oe_q | wbits;
                AW'(REG_OE_CLR):  oe_q  <= oe_q & ~wbits;
                default: ;
            endcase
        end
    end

    // status: software update first, hardware events OR'd on top
    always_comb begin
        st_base = st_q;
        if (wr) begin
            case (bus_addr)
                AW'(REG_IRQ):     st_base = wbits;
                AW'(REG_IRQ_SET): st_base = st_q | wbits;
                AW'(REG_IRQ_CLR): st_base = st_q & ~wbits;
                default: ;
            endcase
        end
        st_d = st_base | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            wake_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            wake_q <= |(hit & wake_v);
        end
    end

    // per-pin configuration words
    for (genvar i = 0; i < NPIN; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (wr && bus_addr == AW'(REG_CFG0 + i)) begin
                cfg_q[i].od   <= bus_wdata[CFG_OD_BIT];
                cfg_q[i].trig <= bus_wdata[CFG_TRIG_LSB +: 3];
                cfg_q[i].wake <= bus_wdata[CFG_WAKE_BIT];
            end
        end
        assign od_v[i]   = cfg_q[i].od;
        assign wake_v[i] = cfg_q[i].wake;
        assign trig_v[i] = cfg_q[i].trig;
    end

    lpg_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
    );

    lpg_detect #(.N(NPIN)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .trig(trig_v), .hit(hit)
    );

    lpg_drive #(.N(NPIN)) u_drive (
        .od(od_v), .dat(out_q), .en(oe_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(REG_OUT): bus_rdata[PIN_MSB:PIN_LSB] = out_q;
            AW'(REG_OE):  bus_rdata[PIN_MSB:PIN_LSB] = oe_q;
            AW'(REG_IRQ): bus_rdata[PIN_MSB:PIN_LSB] = st_q;
            AW'(REG_IN):  bus_rdata[PIN_MSB:PIN_LSB] = lvl;
            default: ;
        endcase
        for (int i = 0; i < NPIN; i++) begin
            if (bus_addr == AW'(REG_CFG0 + i)) begin
                bus_rdata[CFG_OD_BIT]        = cfg_q[i].od;
                bus_rdata[CFG_TRIG_LSB +: 3] = cfg_q[i].trig;
                bus_rdata[CFG_WAKE_BIT]      = cfg_q[i].wake;
            end
        end
    end

    assign irq_o  = |st_q;
    assign wake_o = wake_q;

    // R7: a detected event is always visible in status on the next cycle
    a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((st_q & $past(hit)) == $past(hit)));

    // R10: a wake request is backed by a set status bit of a wake-enabled pin
    a_r10_wake_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ((st_q & $past(wake_v)) != '0));

    // R3: set alias forces the written ones
    a_r3_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(REG_OUT_SET)) |=> ((out_q & $past(wbits)) == $past(wbits)));

    // R3: clear alias removes the written ones
    a_r3_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == AW'(REG_OE_CLR)) |=> ((oe_q & $past(wbits)) == '0));
endmodule

// File: tb/lpg_ctrl_bench.sv
module lpg_ctrl_bench;
    localparam int N  = 22;
    localparam int AW = 6;
    localparam int LSB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic          irq_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_on = 0;

    always #4 clk = ~clk;

    lpg_ctrl #(.NPIN(N), .AW(AW)) u_lpg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    // reference model, built from the requirements
    logic [N-1:0] m_out, m_oe, m_st, m_s1, m_s2, m_prev;
    logic [N-1:0] m_od, m_wk;
    logic [2:0]   m_tr [N];
    logic         m_wake;

    function automatic logic ev(input logic [2:0] t, input logic c, input logic p);
        case (t)
            3'd1: return c & ~p;
            3'd2: return ~c & p;
            3'd3: return c ^ p;
            3'd4: return ~c;
            3'd5: return c;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [N-1:0] h, w, sb;
        if (!rst_n) begin
            m_out <= '0; m_oe <= '0; m_st <= '0; m_s1 <= '0; m_s2 <= '0;
            m_prev <= '0; m_od <= '0; m_wk <= '0; m_wake <= 1'b0;
            for (int i = 0; i < N; i++) m_tr[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) h[i] = ev(m_tr[i], m_s2[i], m_prev[i]);
            w  = bus_wdata[LSB +: N];
            sb = m_st;
            if (bus_sel && bus_wr) begin
                case (int'(bus_addr))
                    0: m_out <= w;
                    1: m_out <= m_out | w;
                    2: m_out <= m_out & ~w;
                    3: m_oe  <= w;
                    4: m_oe  <= m_oe | w;
                    5: m_oe  <= m_oe & ~w;
                    6: sb = w;
                    7: sb = m_st | w;
                    8: sb = m_st & ~w;
                    default: ;
                endcase
                if (int'(bus_addr) >= 16 && int'(bus_addr) < 16 + N) begin
                    m_od[int'(bus_addr) - 16] <= bus_wdata[2];
                    m_tr[int'(bus_addr) - 16] <= bus_wdata[9:7];
                    m_wk[int'(bus_addr) - 16] <= bus_wdata[10];
                end
            end
            m_st   <= sb | h;
            m_wake <= |(h & m_wk);
            m_s1   <= pad_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
        end
    end

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r = '0;
        case (a)
            0: r[LSB +: N] = m_out;
            3: r[LSB +: N] = m_oe;
            6: r[LSB +: N] = m_st;
            9: r[LSB +: N] = m_s2;
            default: ;
        endcase
        if (a >= 16 && a < 16 + N) begin
            r[2] = m_od[a-16]; r[9:7] = m_tr[a-16]; r[10] = m_wk[a-16];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycle-by-cycle port monitor (R8, R9, R10)
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            check("R8 irq", {31'd0, irq_o}, {31'd0, |m_st});
            check("R10 wake", {31'd0, wake_o}, {31'd0, m_wake});
            check("R9 pad_oe", 32'(pad_oe), 32'(m_oe & ~(m_od & m_out)));
            check("R9 pad_out", 32'(pad_out), 32'(m_out & ~m_od));
        end
    end

    function automatic logic [31:0] pb(input int p);
        return 32'h1 << (p + LSB);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        // R1 reset state
        for (int a = 0; a < 16 + N; a++) rd_chk("R1 reset read", a, 32'h0);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 irq/wake", {30'd0, irq_o, wake_o}, 32'h0);
        rst_n = 1;
        mon_on = 1;
        idle(2);

        // R2 layout
        wr_reg(0, 32'hFFFF_FFFF);
        @(negedge clk); rd_chk("R2 out all", 0, 32'hFFFF_FC00);
        wr_reg(3, 32'h0000_03FF);
        @(negedge clk); rd_chk("R2 low bits ignored", 3, 32'h0);
        wr_reg(3, pb(0) | pb(21));
        @(negedge clk); rd_chk("R2 pin0/21", 3, 32'h8000_0400);

        // R3 aliases
        wr_reg(2, pb(5) | pb(6));
        @(negedge clk); rd_chk("R3 clr", 0, 32'hFFFF_FC00 & ~(pb(5) | pb(6)));
        wr_reg(1, pb(5));
        @(negedge clk); rd_chk("R3 set", 0, 32'hFFFF_FC00 & ~pb(6));
        wr_reg(1, 32'h0); wr_reg(2, 32'h0);
        @(negedge clk); rd_chk("R3 zero no effect", 0, 32'hFFFF_FC00 & ~pb(6));
        wr_reg(4, pb(3)); wr_reg(5, pb(0));
        @(negedge clk); rd_chk("R3 oe alias", 3, pb(3) | pb(21));

        // R11 config layout
        wr_reg(16 + 4, 32'hFFFF_FFFF);
        @(negedge clk); rd_chk("R11 cfg mask", 16 + 4, 32'h0000_0784);
        wr_reg(16 + 4, 32'h0);

        // R9 open drain on pin 3 (enable 1): data 1 released, data 0 driven low
        wr_reg(16 + 3, 32'h4);
        wr_reg(1, pb(3));
        @(negedge clk); check("R9 od released", 32'(pad_oe[3]), 32'h0);
        wr_reg(2, pb(3));
        @(negedge clk); check("R9 od low", {30'd0, pad_oe[3], pad_out[3]}, 32'h2);
        wr_reg(16 + 3, 32'h0);

        // R4 two-cycle input sync, write ignored
        @(negedge clk); pad_in = 22'h2A_5A5A;
        @(negedge clk); rd_chk("R4 one edge", 9, 32'h0);
        @(negedge clk); rd_chk("R4 two edges", 9, 32'(22'h2A_5A5A) << LSB);
        wr_reg(9, 32'h0);
        @(negedge clk); rd_chk("R4 write ignored", 9, 32'(22'h2A_5A5A) << LSB);
        pad_in = '0; idle(4);
        wr_reg(6, 32'h0);

        // R5 rising edge on pin 7, wake enabled
        wr_reg(16 + 7, (32'd1 << 7) | 32'h400);
        @(negedge clk); pad_in[7] = 1;
        idle(3); rd_chk("R5 rise", 6, pb(7));
        wr_reg(8, pb(7)); idle(2); rd_chk("R5 no repeat", 6, 32'h0);
        // R5 falling on same pin selects falling
        wr_reg(16 + 7, 32'd2 << 7);
        pad_in[7] = 0; idle(3); rd_chk("R5 fall", 6, pb(7));
        wr_reg(8, pb(7));

        // R6 high level on pin 9, R7 clear loses while level holds
        wr_reg(16 + 9, 32'd5 << 7);
        pad_in[9] = 1; idle(3);
        wr_reg(8, pb(9));
        @(negedge clk); rd_chk("R7 clear vs level", 6, pb(9));
        pad_in[9] = 0; idle(3);
        wr_reg(8, pb(9));
        @(negedge clk); rd_chk("R6 level gone clears", 6, 32'h0);
        wr_reg(16 + 9, 32'd7 << 7);
        pad_in[9] = 1; idle(4); rd_chk("R6 code 7 off", 6, 32'h0);
        pad_in = '0; wr_reg(16 + 9, 32'h0); wr_reg(16 + 7, 32'h0);
        idle(3); wr_reg(6, 32'h0);

        // random phase checked against model
        for (int k = 0; k < 4000; k++) begin
            int a;
            @(negedge clk);
            if ($urandom_range(3) == 0) pad_in = N'($urandom);
            a = ($urandom_range(1) == 0) ? int'($urandom_range(9)) : 16 + int'($urandom_range(N - 1));
            if ($urandom_range(2) == 0) begin
                bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = $urandom;
            end else begin
                bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
                #1; check("R2/R4/R6 random read", bus_rdata, m_read(a));
            end
        end
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        idle(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule